// File: doc/BRIEF.md
# DMA Modulo Address Generator

This block produces the next source and destination addresses for one DMA channel. A load strobe sets up each side with a start address, an access-size code, a signed per-access step, a wrap-window code, a minor-loop offset with its own enable, and an end-of-major-loop adjustment. After that, the addresses move only when strobes arrive from the surrounding engine. A read-done strobe steps the source side and a write-done strobe steps the destination side. A shared minor-loop-done strobe adds the minor offset on every side that has it enabled. A shared major-loop-done strobe applies each side's final adjustment.

A wrap-window code other than zero keeps the address inside a naturally aligned power-of-two region, so a circular buffer needs no software help. Both sides also report, at all times, whether the current address or the configured step disagrees with the access size. The bus transactions, the loop counters and the channel arbitration sit outside this block.

Top module: `dma_mod_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both addresses, every stored configuration field and all four error outputs become zero.
- R2: A `load` at a clock edge sets each address to its start input and captures every configuration field. The captured configuration stays in use until the next `load`.
- R3: On `rd_done`, the source address adds its 16-bit step, sign-extended to the address width. On `wr_done`, the destination address does the same with its own step.
- R4: Wrap code 0 disables wrapping. A wrap code n with 1 <= n < AW keeps address bits n and above at their previous value, and the low n bits take the sum. A wrap code n >= AW behaves as code 0.
- R5: On `minor_done`, a side whose minor enable was captured as 1 adds the sign-extended minor offset. When a step occurs in the same cycle, the two increments are summed before the wrap window is applied.
- R6: On `major_done`, each side adds its full-width final adjustment after the windowed step. The adjustment ignores the wrap window.
- R7: In a cycle without `load` and without any strobe that affects a side, that side's address holds its value.
- R8: The access size is 2^s bytes for size code s from 0 to 5; codes 6 and 7 mean 32 bytes. The address error output of a side is high exactly when its current address is not a multiple of its access size.
- R9: The offset error output of a side is high exactly when its captured 16-bit step is not a multiple of its access size.
- R10: When `load` and any strobe occur in the same cycle, the load wins and the strobes have no effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture the start addresses and the configuration |
| src_start | input | AW | Source start address |
| src_size | input | 3 | Source access-size code |
| src_step | input | 16 | Source signed per-access step |
| src_wrap | input | 5 | Source wrap-window code |
| src_minor_en | input | 1 | Source takes the minor-loop offset |
| src_final_adj | input | AW | Source end-of-major adjustment |
| dst_start | input | AW | Destination start address |
| dst_size | input | 3 | Destination access-size code |
| dst_step | input | 16 | Destination signed per-access step |
| dst_wrap | input | 5 | Destination wrap-window code |
| dst_minor_en | input | 1 | Destination takes the minor-loop offset |
| dst_final_adj | input | AW | Destination end-of-major adjustment |
| minor_ofs | input | MW | Signed minor-loop offset, shared by both sides |
| rd_done | input | 1 | Source access completed |
| wr_done | input | 1 | Destination access completed |
| minor_done | input | 1 | Minor loop completed |
| major_done | input | 1 | Major loop exhausted |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| src_addr_err | output | 1 | Source address misaligned to its access size |
| src_step_err | output | 1 | Source step not a multiple of its access size |
| dst_addr_err | output | 1 | Destination address misaligned to its access size |
| dst_step_err | output | 1 | Destination step not a multiple of its access size |

## Verification
The bench builds the block with AW = 24 and MW = 20. With these values the random wrap codes 24 to 31 select a window at least as wide as the address, so the R4 fall-back to unwrapped stepping is exercised often. A 24-bit address also wraps around zero within reach of a few steps. Because MW is smaller than AW, the sign extension of negative minor offsets is exercised as well. Directed cases cover a step that crosses a 256-byte window boundary, a step and a minor offset in the same cycle, a negative final adjustment, and misaligned addresses and steps.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    localparam int STEP_W = 16;
    localparam int WRAP_W = 5;
    localparam int SIZE_W = 3;
    localparam int LSB_W  = 5;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [STEP_W-1:0] step;
        logic [WRAP_W-1:0] wrap;
        logic              minor_en;
    } side_cfg_t;

    // Low-order bit mask of an access size code.
    function automatic logic [LSB_W-1:0] size_lsb_mask(input logic [SIZE_W-1:0] code);
        case (code)
            3'd0:    return 5'b00000;
            3'd1:    return 5'b00001;
            3'd2:    return 5'b00011;
            3'd3:    return 5'b00111;
            3'd4:    return 5'b01111;
            default: return 5'b11111;
        endcase
    endfunction

    // Bits of the address that follow the sum; code 0 selects all bits.
    function automatic logic [63:0] window_mask(input logic [WRAP_W-1:0] code);
        if (code == '0)
            return '1;
        return (64'd1 << code) - 64'd1;
    endfunction

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
    import dma_ag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              addr_err_o,
    output logic              step_err_o
);
    logic [LSB_W-1:0] lsb;

    always_comb begin
        lsb        = size_lsb_mask(size_i);
        addr_err_o = |(addr_i[LSB_W-1:0] & lsb);
        step_err_o = |(step_i[LSB_W-1:0] & lsb);
    end
endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] start_i,
    input  side_cfg_t     cfg_i,
    input  logic [AW-1:0] adj_i,
    input  logic [MW-1:0] minor_ofs_i,
    input  logic          step_i,
    input  logic          minor_i,
    input  logic          major_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_err_o,
    output logic          step_err_o
);
    logic [AW-1:0] addr_q;
    side_cfg_t     cfg_q;
    logic [AW-1:0] adj_q;
    logic [MW-1:0] mofs_q;

    logic [AW-1:0] acc_inc;
    logic [AW-1:0] minor_inc;
    logic [AW-1:0] raw_sum;
    logic [63:0]   mask_full;
    logic [AW-1:0] mask;
    logic [AW-1:0] windowed;
    logic [AW-1:0] addr_d;

    always_comb begin
        acc_inc   = step_i ? {{(AW-STEP_W){cfg_q.step[STEP_W-1]}}, cfg_q.step} : '0;
        minor_inc = (minor_i && cfg_q.minor_en) ? {{(AW-MW){mofs_q[MW-1]}}, mofs_q} : '0;
        raw_sum   = addr_q + acc_inc + minor_inc;
        mask_full = window_mask(cfg_q.wrap);
        mask      = mask_full[AW-1:0];
        windowed  = (addr_q & ~mask) | (raw_sum & mask);
        addr_d    = major_i ? windowed + adj_q : windowed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cfg_q  <= '0;
            adj_q  <= '0;
            mofs_q <= '0;
        end else if (load_i) begin
            addr_q <= start_i;
            cfg_q  <= cfg_i;
            adj_q  <= adj_i;
            mofs_q <= minor_ofs_i;
        end else begin
            addr_q <= addr_d;
        end
    end

    dma_align_chk #(.AW(AW)) align_i (
        .size_i     (cfg_q.size),
        .addr_i     (addr_q),
        .step_i     (cfg_q.step),
        .addr_err_o (addr_err_o),
        .step_err_o (step_err_o)
    );

    assign addr_o = addr_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (addr_q == '0 && !addr_err_o && !step_err_o));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> addr_q == $past(start_i));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i && !(minor_i && cfg_q.minor_en) && !major_i) |=> $stable(addr_q));

    // R4
    window_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !major_i) |=> ((addr_q ^ $past(addr_q)) & ~mask) == '0);

    // R8
    aligned_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_q[LSB_W-1:0] == '0) |-> !addr_err_o);
endmodule

// File: rtl/dma_mod_addr_gen.sv
module dma_mod_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [AW-1:0]     src_start,
    input  logic [SIZE_W-1:0] src_size,
    input  logic [STEP_W-1:0] src_step,
    input  logic [WRAP_W-1:0] src_wrap,
    input  logic              src_minor_en,
    input  logic [AW-1:0]     src_final_adj,
    input  logic [AW-1:0]     dst_start,
    input  logic [SIZE_W-1:0] dst_size,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [WRAP_W-1:0] dst_wrap,
    input  logic              dst_minor_en,
    input  logic [AW-1:0]     dst_final_adj,
    input  logic [MW-1:0]     minor_ofs,
    input  logic              rd_done,
    input  logic              wr_done,
    input  logic              minor_done,
    input  logic              major_done,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic              src_addr_err,
    output logic              src_step_err,
    output logic              dst_addr_err,
    output logic              dst_step_err
);
    side_cfg_t src_cfg;
    side_cfg_t dst_cfg;

    always_comb begin
        src_cfg = '{size: src_size, step: src_step, wrap: src_wrap, minor_en: src_minor_en};
        dst_cfg = '{size: dst_size, step: dst_step, wrap: dst_wrap, minor_en: dst_minor_en};
    end

    dma_addr_side #(.AW(AW), .MW(MW)) src_side_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .start_i     (src_start),
        .cfg_i       (src_cfg),
        .adj_i       (src_final_adj),
        .minor_ofs_i (minor_ofs),
        .step_i      (rd_done),
        .minor_i     (minor_done),
        .major_i     (major_done),
        .addr_o      (src_addr),
        .addr_err_o  (src_addr_err),
        .step_err_o  (src_step_err)
    );

    dma_addr_side #(.AW(AW), .MW(MW)) dst_side_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .start_i     (dst_start),
        .cfg_i       (dst_cfg),
        .adj_i       (dst_final_adj),
        .minor_ofs_i (minor_ofs),
        .step_i      (wr_done),
        .minor_i     (minor_done),
        .major_i     (major_done),
        .addr_o      (dst_addr),
        .addr_err_o  (dst_addr_err),
        .step_err_o  (dst_step_err)
    );
endmodule

// File: tb/dma_mod_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_mod_addr_gen_tb_top;
    localparam int AW = 24;
    localparam int MW = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic load = 1'b0;
    logic [AW-1:0] src_start = '0, dst_start = '0, src_final_adj = '0, dst_final_adj = '0;
    logic [2:0] src_size = '0, dst_size = '0;
    logic [15:0] src_step = '0, dst_step = '0;
    logic [4:0] src_wrap = '0, dst_wrap = '0;
    logic src_minor_en = 1'b0, dst_minor_en = 1'b0;
    logic [MW-1:0] minor_ofs = '0;
    logic rd_done = 1'b0, wr_done = 1'b0, minor_done = 1'b0, major_done = 1'b0;
    logic [AW-1:0] src_addr, dst_addr;
    logic src_addr_err, src_step_err, dst_addr_err, dst_step_err;

    dma_mod_addr_gen #(.AW(AW), .MW(MW)) dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench model state, index 0 = source, 1 = destination
    logic [AW-1:0] m_addr [2];
    logic [2:0]    m_size [2];
    logic [15:0]   m_step [2];
    logic [4:0]    m_wrap [2];
    logic          m_men  [2];
    logic [AW-1:0] m_adj  [2];
    logic [MW-1:0] m_mofs [2];

    function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a, input logic [15:0] st,
            input logic [4:0] w, input logic men, input logic [MW-1:0] mo, input logic [AW-1:0] adj,
            input logic stp, input logic mn, input logic mj);
        logic [AW-1:0] s, r, hi;
        s = a;
        if (stp) s = s + {{(AW-16){st[15]}}, st};
        if (mn && men) s = s + {{(AW-MW){mo[MW-1]}}, mo};
        if (w != 0 && int'(w) < AW) begin
            hi = ~((AW'(1) << w) - AW'(1));
            r  = (a & hi) | (s & ~hi);
        end else begin
            r = s;
        end
        if (mj) r = r + adj;
        return r;
    endfunction

    function automatic logic misaligned(input logic [2:0] sz, input int unsigned v);
        int unsigned bytes;
        bytes = (sz <= 3'd5) ? (32'd1 << sz) : 32'd32;
        return (v % bytes) != 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "src_addr", src_addr, m_addr[0]);
        chk(tag, "dst_addr", dst_addr, m_addr[1]);
        chk({tag, "/R8"}, "src_addr_err", AW'(src_addr_err), AW'(misaligned(m_size[0], 32'(m_addr[0]))));
        chk({tag, "/R8"}, "dst_addr_err", AW'(dst_addr_err), AW'(misaligned(m_size[1], 32'(m_addr[1]))));
        chk({tag, "/R9"}, "src_step_err", AW'(src_step_err), AW'(misaligned(m_size[0], 32'(m_step[0]))));
        chk({tag, "/R9"}, "dst_step_err", AW'(dst_step_err), AW'(misaligned(m_size[1], 32'(m_step[1]))));
    endtask

    // Drives are already set at a falling edge; advance one cycle and check.
    task automatic cycle(input string tag);
        if (load) begin
            m_addr[0] = src_start; m_size[0] = src_size; m_step[0] = src_step;
            m_wrap[0] = src_wrap;  m_men[0]  = src_minor_en; m_adj[0] = src_final_adj; m_mofs[0] = minor_ofs;
            m_addr[1] = dst_start; m_size[1] = dst_size; m_step[1] = dst_step;
            m_wrap[1] = dst_wrap;  m_men[1]  = dst_minor_en; m_adj[1] = dst_final_adj; m_mofs[1] = minor_ofs;
        end else begin
            m_addr[0] = exp_next(m_addr[0], m_step[0], m_wrap[0], m_men[0], m_mofs[0], m_adj[0], rd_done, minor_done, major_done);
            m_addr[1] = exp_next(m_addr[1], m_step[1], m_wrap[1], m_men[1], m_mofs[1], m_adj[1], wr_done, minor_done, major_done);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic strobes(input logic ld, input logic rd, input logic wr, input logic mn, input logic mj);
        load = ld; rd_done = rd; wr_done = wr; minor_done = mn; major_done = mj;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            m_addr[i] = '0; m_size[i] = '0; m_step[i] = '0; m_wrap[i] = '0;
            m_men[i] = 1'b0; m_adj[i] = '0; m_mofs[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R10 and R2: load with strobes asserted, the load wins
        src_start = 24'h1234FC; src_size = 3'd0; src_step = 16'd4; src_wrap = 5'd8;
        dst_start = 24'h000100; dst_size = 3'd0; dst_step = 16'hFFFC; dst_wrap = 5'd0;
        strobes(1, 1, 1, 1, 1);
        cycle("R10");
        chk("R10", "src_addr", src_addr, 24'h1234FC);

        // R4: step crosses a 256-byte window boundary; R3 negative step
        strobes(0, 1, 1, 0, 0);
        cycle("R4");
        chk("R4", "src_addr wrapped", src_addr, 24'h123400);
        chk("R3", "dst_addr negative step", dst_addr, 24'h0000FC);

        // R5: step and minor offset in the same cycle, summed before the window
        src_start = 24'h1234F0; src_step = 16'd8; src_minor_en = 1'b1; minor_ofs = 20'h00010;
        src_final_adj = 24'hFFFFF0;
        strobes(1, 0, 0, 0, 0);
        cycle("R2");
        strobes(0, 1, 0, 1, 0);
        cycle("R5");
        chk("R5", "src_addr step+minor", src_addr, 24'h123408);
        chk("R5", "dst_addr minor disabled", dst_addr, 24'h000100);

        // R6: negative final adjustment ignores the window
        strobes(0, 0, 0, 0, 1);
        cycle("R6");
        chk("R6", "src_addr final adj", src_addr, 24'h1233F8);

        // R7: idle cycles hold
        strobes(0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cycle("R7");
        chk("R7", "src_addr held", src_addr, 24'h1233F8);

        // R8/R9: misaligned address and step for a 4-byte access
        dst_start = 24'h000102; dst_size = 3'd2; dst_step = 16'd6; dst_wrap = 5'd30;
        strobes(1, 0, 0, 0, 0);
        cycle("R2");
        chk("R8", "dst_addr_err", AW'(dst_addr_err), 24'd1);
        chk("R9", "dst_step_err", AW'(dst_step_err), 24'd1);
        strobes(0, 0, 1, 0, 0);
        cycle("R3");
        chk("R8", "dst_addr_err cleared", AW'(dst_addr_err), 24'd0);

        // R4: wrap code >= AW behaves as no wrap, address rolls past the top
        dst_start = 24'hFFFFFC; dst_size = 3'd0; dst_step = 16'd8; dst_wrap = 5'd31;
        strobes(1, 0, 0, 0, 0);
        cycle("R2");
        strobes(0, 0, 1, 0, 0);
        cycle("R4");
        chk("R4", "dst_addr no wrap code>=AW", dst_addr, 24'h000004);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            string tag;
            logic ld;
            ld = ($urandom_range(0, 15) == 0);
            if (ld) begin
                src_size = 3'($urandom_range(0, 7)); dst_size = 3'($urandom_range(0, 7));
                src_step = 16'($urandom); dst_step = 16'($urandom);
                if ($urandom_range(0, 3) != 0) src_step = src_step & ~16'(misaligned(src_size, 1) ? ((src_size <= 3'd5) ? (32'd1 << src_size) - 1 : 31) : 0);
                if ($urandom_range(0, 3) != 0) dst_step = dst_step & ~16'(misaligned(dst_size, 1) ? ((dst_size <= 3'd5) ? (32'd1 << dst_size) - 1 : 31) : 0);
                src_start = AW'($urandom); dst_start = AW'($urandom);
                src_wrap = 5'($urandom); dst_wrap = 5'($urandom);
                src_minor_en = 1'($urandom); dst_minor_en = 1'($urandom);
                src_final_adj = AW'($urandom); dst_final_adj = AW'($urandom);
                minor_ofs = MW'($urandom);
            end
            strobes(ld, 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0));
            if (ld) tag = "R2";
            else if (major_done) tag = "R6";
            else if (minor_done) tag = "R5";
            else if (rd_done || wr_done) tag = "R3";
            else tag = "R7";
            cycle(tag);
        end

        // R1: reset mid-run clears everything
        strobes(0, 1, 1, 1, 1);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            m_addr[i] = '0; m_size[i] = '0; m_step[i] = '0; m_wrap[i] = '0;
            m_men[i] = 1'b0; m_adj[i] = '0; m_mofs[i] = '0;
        end
        @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        strobes(0, 0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule